// File: doc/BRIEF.md
# Pulse-Width Coax Word Receiver

This block takes the logic-level receive side of a shared coax line on which every bit is one active-high pulse: a short pulse means 0 and a long pulse means 1. It recovers a sample point for each bit from that bit's own leading edge. A fixed-length delay line of clock stages counts a set number of cycles from the edge, and the line level at that moment becomes the bit. The recovered bits shift into a cleared 13-bit deserializer. A word is complete when its first bit, which is always 1, arrives at the top position of the register.

When a word completes, the block presents the word in parallel and raises a ready strobe. It marks whether the word is a control word or a data word and checks odd parity over its first twelve bits. For a well-formed control word it issues one-cycle command pulses. A word that fails parity sets a sticky transmit-check flag. The flag is cleared by the matching reset command or by a write command. The ready strobe lasts one cycle for control words. For data words it is stretched so that downstream logic has more time to pick up the parallel data.

Top module: `coax_rx`

## Requirements
- R1: After reset, rx_ready, rx_is_ctrl, xmit_chk, cmd_pulse and rx_word are all 0.
- R2: Each bit is taken from the line level SAMPLE_TAP cycles after the synchronized leading edge, and each edge gives exactly one sample. A pulse still high at that point is a 1 and a pulse already low is a 0.
- R3: rx_word[i] holds bit number i+1, where bit 1 is the first bit received. Bit 1 is always 1 and marks the word boundary.
- R4: rx_ready rises on the (SYNC_STAGES+SAMPLE_TAP+2)th rising clock edge, counting from the first edge at which line_in is high for the word's last pulse.
- R5: rx_ready stays high for 1 cycle after a control word and for 1+STRETCH cycles after a data word.
- R6: rx_is_ctrl equals bit 2 of the received word.
- R7: A word whose bits 1 through 12 do not have odd parity sets xmit_chk and produces no command pulse.
- R8: Command pulses last one cycle and coincide with the first cycle of rx_ready. The index of cmd_pulse maps to the word as follows: 0 poll (bit 4 without bit 5), 1 read (bit 5 without bit 4), 2 write (bit 6), 3 system-available (bit 7), 4 keyboard unlock (bit 8), 5 erase unprotected (bit 9 without bit 3), 6 reset transmit check (bit 10), 7 acknowledge (bit 11), 8 read-poll (bits 4 and 5), 9 alarm (bits 3 and 9). Several commands may fire together.
- R9: A control word that sets bit 6 together with bit 4 or bit 5 produces no command pulse.
- R10: xmit_chk is cleared by a parity-valid, legal control word that carries reset transmit check or write.
- R11: Data words produce no command pulses and leave xmit_chk unchanged.
- R12: The deserializer is cleared after every word, so back-to-back words decode independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Comparator output of the coax line, high during a pulse |
| rx_word | output | 13 | Last received word, index i holds bit i+1 |
| rx_ready | output | 1 | Word-ready strobe |
| rx_is_ctrl | output | 1 | Last word was a control word |
| cmd_pulse | output | 10 | One-cycle command pulses, positions as in R8 |
| xmit_chk | output | 1 | Sticky transmit-check flag |

## Verification
The bench builds the block with its default values: a two-stage synchronizer, an eight-stage delay line tapped at six and a two-cycle stretch. It drives short pulses of four cycles and long pulses of eleven cycles. These widths fall on either side of the tap, so both bit values are decided well away from the tap point, and the fixed tap turns the ready latency into an exact count of ten edges. The two-cycle stretch gives a three-cycle data strobe that is easy to tell apart from the single-cycle control strobe. Random words with injected parity faults and directed illegal command combinations exercise the flag and the decode rules.

// File: rtl/coax_rx_pkg.sv
package coax_rx_pkg;
  localparam int WORD_BITS = 13;
  localparam int CMD_N     = 10;

  localparam int C_POLL   = 0;
  localparam int C_READ   = 1;
  localparam int C_WRITE  = 2;
  localparam int C_SYSAV  = 3;
  localparam int C_UNLOCK = 4;
  localparam int C_ERASE  = 5;
  localparam int C_RSTXC  = 6;
  localparam int C_ACK    = 7;
  localparam int C_RDPOLL = 8;
  localparam int C_ALARM  = 9;

  typedef logic [WORD_BITS-1:0] word_t;
  typedef logic [CMD_N-1:0]     cmd_t;

  // bit n of the line word (n counts from 1, first received)
  function automatic logic wbit(input word_t w, input int n);
    return w[n-1];
  endfunction

  // odd parity across bits 1..12
  function automatic logic parity_good(input word_t w);
    return ^w[WORD_BITS-2:0];
  endfunction

  function automatic logic combo_illegal(input word_t w);
    return wbit(w, 6) & (wbit(w, 4) | wbit(w, 5));
  endfunction

  function automatic cmd_t decode_cmd(input word_t w);
    cmd_t c;
    c           = '0;
    c[C_POLL]   = wbit(w, 4) & ~wbit(w, 5);
    c[C_READ]   = wbit(w, 5) & ~wbit(w, 4);
    c[C_RDPOLL] = wbit(w, 4) &  wbit(w, 5);
    c[C_WRITE]  = wbit(w, 6);
    c[C_SYSAV]  = wbit(w, 7);
    c[C_UNLOCK] = wbit(w, 8);
    c[C_ERASE]  = wbit(w, 9) & ~wbit(w, 3);
    c[C_ALARM]  = wbit(w, 9) &  wbit(w, 3);
    c[C_RSTXC]  = wbit(w, 10);
    c[C_ACK]    = wbit(w, 11);
    return c;
  endfunction

  // shift register holds first bit at the top; the word puts it at index 0
  function automatic word_t reverse_bits(input word_t s);
    word_t r;
    for (int i = 0; i < WORD_BITS; i++) r[i] = s[WORD_BITS-1-i];
    return r;
  endfunction
endpackage

// File: rtl/cxr_edge_sampler.sv
module cxr_edge_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_STAGES  = 8,
  parameter int SAMPLE_TAP  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic sample_stb,
  output logic bit_val,
  output logic dly_overrun
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_q;
  logic                   line_s;
  logic                   lead;
  logic [DLY_STAGES-1:0]  dly_q;

  assign line_s = sync_q[SYNC_STAGES-1];
  assign lead   = line_s & ~line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      line_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      line_q <= line_s;
    end
  end

  // the edge travels down the line; reaching the tap fires one sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dly_q <= '0;
    else if (sample_stb) dly_q <= '0;
    else                 dly_q <= {dly_q[DLY_STAGES-2:0], lead};
  end

  assign sample_stb  = dly_q[SAMPLE_TAP-1];
  assign bit_val     = line_s;
  assign dly_overrun = |dly_q[DLY_STAGES-1:SAMPLE_TAP];
endmodule

// File: rtl/cxr_deser.sv
module cxr_deser
  import coax_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sample_stb,
  input  logic  bit_val,
  output logic  word_done,
  output word_t word_o
);
  word_t sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sr_q <= '0;
    else if (word_done)  sr_q <= '0;
    else if (sample_stb) sr_q <= {sr_q[WORD_BITS-2:0], bit_val};
  end

  assign word_done = sr_q[WORD_BITS-1];
  assign word_o    = reverse_bits(sr_q);
endmodule

// File: rtl/cxr_decoder.sv
module cxr_decoder
  import coax_rx_pkg::*;
#(
  parameter int STRETCH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  word_done,
  input  word_t word_i,
  output word_t rx_word,
  output logic  rx_ready,
  output logic  rx_is_ctrl,
  output cmd_t  cmd_pulse,
  output logic  xmit_chk,
  output logic  par_err_evt
);
  localparam int CNT_W = $clog2(STRETCH + 2);

  logic             is_ctrl;
  logic             par_ok;
  logic             cmd_ok;
  cmd_t             cmd_d;
  logic [CNT_W-1:0] hold_q;

  assign is_ctrl     = wbit(word_i, 2);
  assign par_ok      = parity_good(word_i);
  assign cmd_ok      = word_done & is_ctrl & par_ok & ~combo_illegal(word_i);
  assign cmd_d       = cmd_ok ? decode_cmd(word_i) : '0;
  assign par_err_evt = word_done & ~par_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word    <= '0;
      rx_is_ctrl <= 1'b0;
      cmd_pulse  <= '0;
    end else begin
      cmd_pulse <= cmd_d;
      if (word_done) begin
        rx_word    <= word_i;
        rx_is_ctrl <= is_ctrl;
      end
    end
  end

  // ready strobe, stretched for data words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready <= 1'b0;
      hold_q   <= '0;
    end else if (word_done) begin
      rx_ready <= 1'b1;
      hold_q   <= is_ctrl ? '0 : CNT_W'(STRETCH);
    end else if (rx_ready) begin
      if (hold_q == '0) rx_ready <= 1'b0;
      else              hold_q   <= hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    xmit_chk <= 1'b0;
    else if (par_err_evt)                          xmit_chk <= 1'b1;
    else if (cmd_d[C_RSTXC] || cmd_d[C_WRITE])     xmit_chk <= 1'b0;
  end
endmodule

// File: rtl/coax_rx.sv
module coax_rx
  import coax_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_STAGES  = 8,
  parameter int SAMPLE_TAP  = 6,
  parameter int STRETCH     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_in,
  output logic [WORD_BITS-1:0] rx_word,
  output logic                 rx_ready,
  output logic                 rx_is_ctrl,
  output logic [CMD_N-1:0]     cmd_pulse,
  output logic                 xmit_chk
);
  logic  sample_stb;
  logic  bit_val;
  logic  dly_overrun;
  logic  word_done;
  logic  par_err_evt;
  word_t deser_word;

  cxr_edge_sampler #(
    .SYNC_STAGES(SYNC_STAGES),
    .DLY_STAGES (DLY_STAGES),
    .SAMPLE_TAP (SAMPLE_TAP)
  ) u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .sample_stb (sample_stb),
    .bit_val    (bit_val),
    .dly_overrun(dly_overrun)
  );

  cxr_deser u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_stb(sample_stb),
    .bit_val   (bit_val),
    .word_done (word_done),
    .word_o    (deser_word)
  );

  cxr_decoder #(.STRETCH(STRETCH)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_done  (word_done),
    .word_i     (deser_word),
    .rx_word    (rx_word),
    .rx_ready   (rx_ready),
    .rx_is_ctrl (rx_is_ctrl),
    .cmd_pulse  (cmd_pulse),
    .xmit_chk   (xmit_chk),
    .par_err_evt(par_err_evt)
  );
endmodule

// File: rtl/coax_rx_chk.sv
module coax_rx_chk
  import coax_rx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sample_stb,
  input logic       dly_overrun,
  input logic       word_done,
  input logic       par_err_evt,
  input logic       rx_ready,
  input logic       rx_is_ctrl,
  input logic [CMD_N-1:0] cmd_pulse,
  input logic       xmit_chk
);
  a_r2_one_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    !dly_overrun);

  a_r4_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(word_done));

  a_r5_ctrl_ready_short: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_ready) && rx_is_ctrl) |=> !rx_ready);

  a_r7_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_evt |=> (xmit_chk && cmd_pulse == '0));

  a_r8_cmd_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |-> $rose(rx_ready));

  a_r9_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_pulse[C_WRITE] && (cmd_pulse[C_READ] || cmd_pulse[C_POLL] || cmd_pulse[C_RDPOLL])));

  a_r11_cmd_only_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |-> rx_is_ctrl);
endmodule

bind coax_rx coax_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .dly_overrun(dly_overrun),
  .word_done  (word_done),
  .par_err_evt(par_err_evt),
  .rx_ready   (rx_ready),
  .rx_is_ctrl (rx_is_ctrl),
  .cmd_pulse  (cmd_pulse),
  .xmit_chk   (xmit_chk)
);

// File: tb/coax_rx_tb.sv
module coax_rx_tb;
  localparam int SYNC = 2;
  localparam int TAP  = 6;
  localparam int STR  = 2;
  localparam int ZERO_HI = 4;
  localparam int ONE_HI  = 11;
  localparam int GAP     = 6;
  localparam int LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_in = 1'b0;
  logic [12:0] rx_word;
  logic        rx_ready;
  logic        rx_is_ctrl;
  logic [9:0]  cmd_pulse;
  logic        xmit_chk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int edge_cyc = 0;
  int rise_cyc = 0;
  int width = 0;
  bit cap_valid = 0;
  bit prev_ready = 0;
  logic [12:0] cap_word;
  logic        cap_ctrl;
  logic [9:0]  cap_cmd;
  bit exp_xchk = 0;

  always #2 clk = ~clk;

  coax_rx #(.SYNC_STAGES(SYNC), .DLY_STAGES(8), .SAMPLE_TAP(TAP), .STRETCH(STR)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .rx_word(rx_word),
    .rx_ready(rx_ready), .rx_is_ctrl(rx_is_ctrl), .cmd_pulse(cmd_pulse),
    .xmit_chk(xmit_chk)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_ready && !prev_ready) begin
      rise_cyc  <= cyc;
      cap_word  <= rx_word;
      cap_ctrl  <= rx_is_ctrl;
      cap_cmd   <= cmd_pulse;
      cap_valid <= 1'b1;
      width     <= 1;
    end else if (rx_ready) begin
      width <= width + 1;
    end
    prev_ready <= rx_ready;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // builds a word: bits[0] is bit 1 (first sent)
  function automatic logic [12:0] mk_word(input bit ctrl, input logic [8:0] mid, input bit bad_par);
    logic [12:0] w;
    int ones;
    w = '0;
    w[0] = 1'b1;
    w[1] = ctrl;
    for (int i = 0; i < 9; i++) w[2+i] = mid[i];
    ones = 0;
    for (int i = 0; i < 11; i++) if (w[i]) ones++;
    w[11] = (ones % 2 == 0) ? 1'b1 : 1'b0;
    if (bad_par) w[11] = ~w[11];
    w[12] = 1'b0;
    return w;
  endfunction

  // bit n, n from 1
  function automatic bit b(input logic [12:0] w, input int n);
    return w[n-1];
  endfunction

  function automatic logic [9:0] exp_cmd(input logic [12:0] w);
    logic [9:0] c;
    int ones;
    ones = 0;
    for (int i = 0; i < 12; i++) if (w[i]) ones++;
    c = '0;
    if (!b(w,2) || (ones % 2) == 0) return c;
    if (b(w,6) && (b(w,4) || b(w,5))) return c;
    if (b(w,4) && b(w,5)) c[8] = 1'b1;
    else begin
      c[0] = b(w,4);
      c[1] = b(w,5);
    end
    c[2] = b(w,6);
    c[3] = b(w,7);
    c[4] = b(w,8);
    if (b(w,9)) begin
      if (b(w,3)) c[9] = 1'b1; else c[5] = 1'b1;
    end
    c[6] = b(w,10);
    c[7] = b(w,11);
    return c;
  endfunction

  function automatic bit par_bad(input logic [12:0] w);
    int ones;
    ones = 0;
    for (int i = 0; i < 12; i++) if (w[i]) ones++;
    return (ones % 2) == 0;
  endfunction

  task automatic send_pulse(input bit v);
    @(negedge clk);
    line_in = 1'b1;
    edge_cyc = cyc;
    repeat (v ? ONE_HI : ZERO_HI) @(negedge clk);
    line_in = 1'b0;
    repeat (GAP - 1) @(negedge clk);
  endtask

  task automatic send_and_check(input logic [12:0] w);
    logic [9:0] ec;
    cap_valid = 1'b0;
    for (int i = 0; i < 13; i++) send_pulse(w[i]);
    repeat (10) @(negedge clk);
    ec = exp_cmd(w);
    if (par_bad(w)) exp_xchk = 1'b1;
    else if (ec[2] || ec[6]) exp_xchk = 1'b0;
    check("R12 word seen", 32'(cap_valid), 32'd1);
    check("R2 R3 word", 32'(cap_word), 32'(w));
    check("R6 ctrl flag", 32'(cap_ctrl), 32'(w[1]));
    check("R8 R9 R11 commands", 32'(cap_cmd), 32'(ec));
    check("R7 R10 xmit_chk", 32'(xmit_chk), 32'(exp_xchk));
    check("R4 latency", 32'(rise_cyc - edge_cyc), 32'(SYNC + TAP + 2));
    check("R5 ready width", 32'(width), w[1] ? 32'd1 : 32'(1 + STR));
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [8:0] mid;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 ready", 32'(rx_ready), 0);
    check("R1 ctrl", 32'(rx_is_ctrl), 0);
    check("R1 cmd", 32'(cmd_pulse), 0);
    check("R1 xchk", 32'(xmit_chk), 0);
    check("R1 word", 32'(rx_word), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed: each single command (mid[k] is bit k+3)
    for (int k = 1; k < 9; k++) send_and_check(mk_word(1, 9'(1 << k), 0));
    send_and_check(mk_word(1, 9'b000000011, 0)); // bits 3,4 -> poll
    send_and_check(mk_word(1, 9'b000000110, 0)); // R8 read-poll
    send_and_check(mk_word(1, 9'b001000001, 0)); // R8 alarm
    send_and_check(mk_word(1, 9'b000001100, 0)); // R9 bits 5+6
    send_and_check(mk_word(1, 9'b000001010, 0)); // R9 bits 4+6
    send_and_check(mk_word(0, 9'b111111111, 0)); // data, all ones
    send_and_check(mk_word(1, 9'b000000010, 1)); // R7 parity fail
    send_and_check(mk_word(0, 9'b010000000, 0)); // R11 data keeps flag
    send_and_check(mk_word(1, 9'b010000000, 0)); // R10 reset xmit check
    send_and_check(mk_word(0, 9'b000000000, 1)); // R7 data parity fail
    send_and_check(mk_word(1, 9'b000001100, 0)); // R9 illegal does not clear
    send_and_check(mk_word(1, 9'b000001000, 0)); // R10 write clears

    // random mix
    for (int n = 0; n < 40; n++) begin
      mid = 9'($urandom) & 9'($urandom);
      send_and_check(mk_word(1'($urandom), mid, ($urandom % 8) == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule